// File: doc/BRIEF.md
# Two-Core Cache Partition Tuner

This block divides a fixed pool of cache allocation units (colors or ways) between two cores and adjusts that division at run time. It works in epochs. At the end of each epoch the surrounding logic pulses `epoch_end` and presents the miss counts that each core produced during that epoch. The tuner adds the two counts into one cost figure. It then uses that figure to search for a better division by hill-climbing.

Each round of the search has up to three epochs. The first epoch measures the present division. The second measures the division that moves one unit from core 0 to core 1. The third measures the division that moves one unit from core 1 to core 0. A trial that would leave either core with no units is left out. When the round ends, the tuner picks the cheapest of the measured candidates. If that is the present division, the tuner raises `done` and keeps the division from then on. Otherwise the winner becomes the new present division and a new round starts.

Top module: `partition_tuner`

## Requirements
- R1: In the cycle after reset, `quota_c0` is 8, `quota_c1` is 8 and `done` is 0.
- R2: `quota_c0 + quota_c1` always equals 16, and each quota is always at least 1.
- R3: A round measures the base split B (B is the core 0 quota) for one epoch. It then applies B-1 to core 0 for one epoch, and after that B+1 to core 0 for one epoch.
- R4: A trial that would give either core fewer than 1 unit is skipped. With B=1 the round goes straight from B to B+1. With B=15 the round decides right after the B-1 trial. A skipped trial loses to every measured candidate.
- R5: An epoch's cost is the sum of `miss_c0` and `miss_c1`, held in 32 bits. If the sum would pass 0xFFFFFFFF, it becomes 0xFFFFFFFF.
- R6: At the end of a round, the next base is the candidate with the lowest cost. If the present split ties for lowest, it is kept. If the two trials tie for lowest, the B-1 trial is chosen over the B+1 trial.
- R7: When the present split wins a round, `done` rises in the cycle after the final epoch pulse and the quotas return to B. After that, `done` stays 1 and the quotas stay fixed, whatever `epoch_end` does, until the next reset.
- R8: The quota outputs change only in the cycle that directly follows a cycle where `epoch_end` is 1.
- R9: After the base moves to a neighbour, the new base is measured again for a full epoch before its own neighbours are tried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| epoch_end | input | 1 | One-cycle pulse that closes an epoch |
| miss_c0 | input | 32 | Core 0 miss count for the epoch being closed |
| miss_c1 | input | 32 | Core 1 miss count for the epoch being closed |
| quota_c0 | output | 5 | Units given to core 0 |
| quota_c1 | output | 5 | Units given to core 1 |
| done | output | 1 | The tuner has settled and the split is final |

## Verification
The assertions take the miss counts as meaningful only in the cycle where `epoch_end` is high. They also assume each pulse lasts exactly one cycle and closes exactly one epoch. The bench keeps to this. It drives the counts and the pulse together on a falling edge, drops the pulse after one cycle, and leaves idle cycles between pulses so the hold-between-pulses property is exercised. The cost inputs come from arithmetic cost curves over the core 0 quota: V-shaped curves with their minimum at every split from 1 to 15, a flat curve, a curve where the two trials tie, and counts near the 32-bit limit that push the sum into saturation.

// File: rtl/ptune_pkg.sv
package ptune_pkg;

    localparam int COST_W = 32;

    typedef logic [COST_W-1:0] cost_t;

    typedef enum logic [1:0] {
        STEP_BASE  = 2'd0,
        STEP_LOWER = 2'd1,
        STEP_UPPER = 2'd2,
        STEP_FINAL = 2'd3
    } step_e;

    typedef enum logic [1:0] {
        PICK_BASE  = 2'd0,
        PICK_LOWER = 2'd1,
        PICK_UPPER = 2'd2
    } pick_e;

    typedef struct packed {
        logic  valid;
        cost_t cost;
    } cand_t;

    // Candidate a strictly beats b: a was measured and is cheaper,
    // or b was never measured.
    function automatic logic strictly_beats(cand_t a, cand_t b);
        return a.valid && (!b.valid || (a.cost < b.cost));
    endfunction

endpackage

// File: rtl/ptune_cost_sum.sv
module ptune_cost_sum
    import ptune_pkg::*;
#(
    parameter int MISS_W = 32
) (
    input  logic [MISS_W-1:0] cnt_a,
    input  logic [MISS_W-1:0] cnt_b,
    output cost_t             total
);
    localparam int WIDE_W = (MISS_W > COST_W ? MISS_W : COST_W) + 1;

    logic [WIDE_W-1:0] wide_sum;
    logic              over;

    always_comb begin
        wide_sum = WIDE_W'(cnt_a) + WIDE_W'(cnt_b);
        over     = (wide_sum > WIDE_W'({COST_W{1'b1}}));
        total    = over ? {COST_W{1'b1}} : wide_sum[COST_W-1:0];
    end
endmodule

// File: rtl/ptune_cand_store.sv
module ptune_cand_store
    import ptune_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  pick_e wr_slot,
    input  cost_t wr_cost,
    output cand_t view_base,
    output cand_t view_lower,
    output cand_t view_upper
);
    cand_t slot_q [3];
    cand_t slot_d [3];

    // Next-state view: a write to the base slot opens a new round,
    // so both neighbour slots fall back to unmeasured.
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            if (wr_slot == PICK_BASE) begin
                slot_d[PICK_LOWER] = '{valid: 1'b0, cost: '0};
                slot_d[PICK_UPPER] = '{valid: 1'b0, cost: '0};
            end
            slot_d[wr_slot] = '{valid: 1'b1, cost: wr_cost};
        end
    end

    generate
        for (genvar g = 0; g < 3; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[g] <= '{valid: 1'b0, cost: '0};
                end else begin
                    slot_q[g] <= slot_d[g];
                end
            end
        end
    endgenerate

    assign view_base  = slot_d[PICK_BASE];
    assign view_lower = slot_d[PICK_LOWER];
    assign view_upper = slot_d[PICK_UPPER];
endmodule

// File: rtl/ptune_select.sv
module ptune_select
    import ptune_pkg::*;
(
    input  cand_t c_base,
    input  cand_t c_lower,
    input  cand_t c_upper,
    output pick_e winner,
    output cost_t win_cost
);
    cand_t best;

    // Visiting order sets tie priority: base, then lower, then upper.
    always_comb begin
        winner = PICK_BASE;
        best   = c_base;
        if (strictly_beats(c_lower, best)) begin
            winner = PICK_LOWER;
            best   = c_lower;
        end
        if (strictly_beats(c_upper, best)) begin
            winner = PICK_UPPER;
            best   = c_upper;
        end
        win_cost = best.cost;
    end
endmodule

// File: rtl/ptune_seq.sv
module ptune_seq
    import ptune_pkg::*;
#(
    parameter  int TOTAL_UNITS = 16,
    parameter  int MIN_UNITS   = 1,
    localparam int QW          = $clog2(TOTAL_UNITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          epoch_end,
    input  pick_e         winner,
    output logic          wr_en,
    output pick_e         wr_slot,
    output logic [QW-1:0] quota_a,
    output logic          settled
);
    localparam logic [QW-1:0] START_Q = QW'(TOTAL_UNITS / 2);
    localparam logic [QW-1:0] LOW_Q   = QW'(MIN_UNITS);
    localparam logic [QW-1:0] HIGH_Q  = QW'(TOTAL_UNITS - MIN_UNITS);

    step_e         step_q, step_d;
    logic [QW-1:0] base_q, base_d;
    logic [QW-1:0] quota_q, quota_d;
    logic          lower_ok, upper_ok, decide;

    assign lower_ok = (base_q > LOW_Q);
    assign upper_ok = (base_q < HIGH_Q);

    always_comb begin
        wr_en   = epoch_end && (step_q != STEP_FINAL);
        wr_slot = PICK_BASE;
        case (step_q)
            STEP_LOWER: wr_slot = PICK_LOWER;
            STEP_UPPER: wr_slot = PICK_UPPER;
            default:    wr_slot = PICK_BASE;
        endcase
    end

    always_comb begin
        step_d  = step_q;
        base_d  = base_q;
        quota_d = quota_q;
        decide  = 1'b0;
        if (epoch_end) begin
            case (step_q)
                STEP_BASE: begin
                    if (lower_ok) begin
                        step_d  = STEP_LOWER;
                        quota_d = base_q - 1'b1;
                    end else if (upper_ok) begin
                        step_d  = STEP_UPPER;
                        quota_d = base_q + 1'b1;
                    end else begin
                        decide = 1'b1;
                    end
                end
                STEP_LOWER: begin
                    if (upper_ok) begin
                        step_d  = STEP_UPPER;
                        quota_d = base_q + 1'b1;
                    end else begin
                        decide = 1'b1;
                    end
                end
                STEP_UPPER: decide = 1'b1;
                default: ;
            endcase
        end
        if (decide) begin
            case (winner)
                PICK_LOWER: begin
                    base_d  = base_q - 1'b1;
                    quota_d = base_q - 1'b1;
                    step_d  = STEP_BASE;
                end
                PICK_UPPER: begin
                    base_d  = base_q + 1'b1;
                    quota_d = base_q + 1'b1;
                    step_d  = STEP_BASE;
                end
                default: begin
                    quota_d = base_q;
                    step_d  = STEP_FINAL;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= STEP_BASE;
            base_q  <= START_Q;
            quota_q <= START_Q;
        end else begin
            step_q  <= step_d;
            base_q  <= base_d;
            quota_q <= quota_d;
        end
    end

    assign quota_a = quota_q;
    assign settled = (step_q == STEP_FINAL);

    assert_quota_range_R2: assert property (@(posedge clk) disable iff (rst)
        (quota_q >= LOW_Q) && (quota_q <= HIGH_Q));

    assert_quota_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !epoch_end |=> $stable(quota_q));

    assert_lower_trial_R3: assert property (@(posedge clk) disable iff (rst)
        (step_q == STEP_BASE && epoch_end && lower_ok) |=> (quota_q == $past(base_q) - 1'b1));

    assert_skip_lower_R4: assert property (@(posedge clk) disable iff (rst)
        (step_q == STEP_BASE && epoch_end && !lower_ok && upper_ok) |=> (step_q == STEP_UPPER));

    assert_settle_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        settled |=> (settled && $stable(quota_q)));

    assert_settle_at_base_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> (quota_q == base_q));

    assert_fresh_round_R9: assert property (@(posedge clk) disable iff (rst)
        (decide && winner != PICK_BASE) |=> (step_q == STEP_BASE));
endmodule

// File: rtl/partition_tuner.sv
module partition_tuner
    import ptune_pkg::*;
#(
    parameter  int TOTAL_UNITS = 16,
    parameter  int MIN_UNITS   = 1,
    parameter  int MISS_W      = 32,
    localparam int QW          = $clog2(TOTAL_UNITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              epoch_end,
    input  logic [MISS_W-1:0] miss_c0,
    input  logic [MISS_W-1:0] miss_c1,
    output logic [QW-1:0]     quota_c0,
    output logic [QW-1:0]     quota_c1,
    output logic              done
);
    cost_t epoch_cost;
    cand_t v_base, v_lower, v_upper;
    pick_e winner;
    cost_t win_cost;
    logic  wr_en;
    pick_e wr_slot;
    logic [QW-1:0] q_a;

    ptune_cost_sum #(.MISS_W(MISS_W)) u_cost (
        .cnt_a (miss_c0),
        .cnt_b (miss_c1),
        .total (epoch_cost)
    );

    ptune_cand_store u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_cost    (epoch_cost),
        .view_base  (v_base),
        .view_lower (v_lower),
        .view_upper (v_upper)
    );

    ptune_select u_select (
        .c_base   (v_base),
        .c_lower  (v_lower),
        .c_upper  (v_upper),
        .winner   (winner),
        .win_cost (win_cost)
    );

    ptune_seq #(.TOTAL_UNITS(TOTAL_UNITS), .MIN_UNITS(MIN_UNITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .epoch_end (epoch_end),
        .winner    (winner),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .quota_a   (q_a),
        .settled   (done)
    );

    assign quota_c0 = q_a;
    assign quota_c1 = QW'(TOTAL_UNITS) - q_a;

    assert_cost_floor_R5: assert property (@(posedge clk) disable iff (rst)
        epoch_end |-> ((COST_W'(miss_c0) <= epoch_cost) && (COST_W'(miss_c1) <= epoch_cost)));

    assert_winner_cheapest_R6: assert property (@(posedge clk) disable iff (rst)
        epoch_end |-> ((!v_lower.valid || win_cost <= v_lower.cost) &&
                       (!v_upper.valid || win_cost <= v_upper.cost) &&
                       (win_cost <= v_base.cost)));
endmodule

// File: tb/test_partition_tuner.sv
module test_partition_tuner;
    localparam int CLK_PERIOD = 10;
    localparam int TOTAL      = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        epoch_end = 1'b0;
    logic [31:0] miss_c0 = '0;
    logic [31:0] miss_c1 = '0;
    logic [4:0]  quota_c0, quota_c1;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model of the search
    int  m_step;   // 0 base, 1 lower, 2 upper, 3 final
    int  m_base, m_q;
    longint m_cost [3];
    bit  m_val [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    partition_tuner i_partition_tuner (
        .clk       (clk),
        .rst       (rst),
        .epoch_end (epoch_end),
        .miss_c0   (miss_c0),
        .miss_c1   (miss_c1),
        .quota_c0  (quota_c0),
        .quota_c1  (quota_c1),
        .done      (done)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // miss counts per core for a scenario at a given core 0 quota
    task automatic costs(int mode, int tgt, int q, output logic [31:0] c0, output logic [31:0] c1);
        int d;
        d = (q > tgt) ? q - tgt : tgt - q;
        case (mode)
            0: begin c0 = 32'(100 + 10 * d - q); c1 = 32'(q); end
            1: begin c0 = 32'd450; c1 = 32'd50; end
            2: begin c0 = (q == 8) ? 32'd300 : 32'd200; c1 = 32'd0; end
            default: begin
                c0 = (q == 7) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF;
                c1 = (q == 8) ? 32'hFFFF_FFFF : 32'd0;
            end
        endcase
    endtask

    task automatic model_reset();
        m_step = 0; m_base = 8; m_q = 8;
        for (int i = 0; i < 3; i++) begin m_val[i] = 0; m_cost[i] = 0; end
    endtask

    task automatic model_step(logic [31:0] c0, logic [31:0] c1);
        longint s;
        int w;
        bit dec;
        s = longint'(c0) + longint'(c1);
        if (s > 64'hFFFF_FFFF) s = 64'hFFFF_FFFF;   // R5 saturation
        dec = 0;
        if (m_step == 3) return;
        if (m_step == 0) begin
            m_cost[0] = s; m_val[0] = 1; m_val[1] = 0; m_val[2] = 0;
            if (m_base > 1)       begin m_step = 1; m_q = m_base - 1; end
            else if (m_base < 15) begin m_step = 2; m_q = m_base + 1; end
            else dec = 1;
        end else if (m_step == 1) begin
            m_cost[1] = s; m_val[1] = 1;
            if (m_base < 15) begin m_step = 2; m_q = m_base + 1; end
            else dec = 1;
        end else begin
            m_cost[2] = s; m_val[2] = 1; dec = 1;
        end
        if (dec) begin
            w = 0;
            if (m_val[1] && m_cost[1] < m_cost[w]) w = 1;
            if (m_val[2] && m_cost[2] < m_cost[w]) w = 2;
            if (w == 0) begin m_step = 3; m_q = m_base; end
            else begin
                m_base = (w == 1) ? m_base - 1 : m_base + 1;
                m_q = m_base; m_step = 0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; epoch_end = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(quota_c0 == 8, "R1 quota_c0", quota_c0, 8);
        check(quota_c1 == 8, "R1 quota_c1", quota_c1, 8);
        check(done == 1'b0, "R1 done", done, 0);
        model_reset();
    endtask

    task automatic pulse(logic [31:0] c0, logic [31:0] c1);
        miss_c0 = c0; miss_c1 = c1; epoch_end = 1'b1;
        @(negedge clk);
        epoch_end = 1'b0;
        miss_c0 = 32'hDEAD_BEEF; miss_c1 = 32'hDEAD_BEEF;
    endtask

    task automatic run_scenario(int mode, int tgt, int exp_final, string tag);
        logic [31:0] c0, c1;
        int q_before, guard;
        do_reset();
        guard = 0;
        while (m_step != 3 && guard < 120) begin
            guard++;
            check(int'(quota_c0) == m_q, {tag, " R3 R6 R9 quota_c0 track"}, quota_c0, m_q);
            check(int'(quota_c0) + int'(quota_c1) == TOTAL && quota_c0 >= 1 && quota_c1 >= 1,
                  {tag, " R2 quota sum"}, int'(quota_c0) + int'(quota_c1), TOTAL);
            costs(mode, tgt, m_q, c0, c1);
            pulse(c0, c1);
            model_step(c0, c1);
            check(int'(quota_c0) == m_q, {tag, " R8 update after pulse"}, quota_c0, m_q);
            q_before = quota_c0;
            @(negedge clk);
            @(negedge clk);
            check(int'(quota_c0) == q_before, {tag, " R8 hold between pulses"}, quota_c0, q_before);
            check(done == (m_step == 3), {tag, " R7 done flag"}, done, (m_step == 3));
        end
        check(int'(quota_c0) == exp_final, {tag, " R6 final split"}, quota_c0, exp_final);
        check(done == 1'b1, {tag, " R7 done raised"}, done, 1);
        for (int k = 0; k < 3; k++) begin
            pulse(32'd5 * 32'(k), 32'd1);
            @(negedge clk);
            check(int'(quota_c0) == exp_final && done, {tag, " R7 hold after done"}, quota_c0, exp_final);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // V-shaped costs with the minimum at every legal split (R4 at 1 and 15)
        for (int t = 1; t <= 15; t++) begin
            run_scenario(0, t, t, "V");
        end
        // flat cost: present split kept on ties (R6), settles at 8 after three epochs
        run_scenario(1, 0, 8, "flat");
        // trials tie below base: lower trial preferred (R6)
        run_scenario(2, 0, 7, "tie");
        // saturating cost sum (R5)
        run_scenario(3, 0, 7, "sat");

        // explicit R4 edge: walk to base 1, check next trial is 2
        do_reset();
        begin
            logic [31:0] c0, c1;
            while (!(m_step == 0 && m_base == 1)) begin
                costs(0, 1, m_q, c0, c1);
                pulse(c0, c1);
                model_step(c0, c1);
            end
            @(negedge clk);
            check(quota_c0 == 1, "R4 base at 1", quota_c0, 1);
            pulse(32'd10, 32'd0);
            @(negedge clk);
            check(quota_c0 == 2, "R4 lower trial skipped at base 1", quota_c0, 2);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule